// File: doc/BRIEF.md
# Error-Compensated Fixed-Width Booth Multiplier

This block multiplies two N-bit two's-complement operands and returns an N-bit result that approximates the upper half of the 2N-bit product. The default is N = 8, and N must be even and at least 4. The multiplier operand is recoded into radix-4 Booth digits in the range -2 to +2. Each digit selects one partial-product row. A sign-bit inversion plus one folded constant replaces sign extension.

Only the partial-product bits at weight 2^(N-1) and above enter the adder. That is the N output columns plus one guard column. Every lower bit-product is discarded. In its place, a one-bit compensation term is formed from the bit-products at weight 2^(N-2) and added at the guard weight. The guard column then supplies a rounding carry into the output. This removes most of the bias that plain truncation leaves, at the cost of one extra column and a few gates.

The result is registered behind a valid strobe, with one cycle of latency. The block suits filter and transform datapaths that keep a fixed word width from stage to stage.

Top module: `fwb_mult`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and prod_o is 0.
- R2: On each rising clock edge, valid_o takes the value of valid_i. When valid_i was 1, prod_o at that same edge takes the result for the a_i and b_i sampled then.
- R3: When valid_i is 0 at a rising edge, prod_o keeps its previous value, whatever a_i and b_i are.
- R4: Digit i (i = 0 .. N/2-1) is formed from the triplet {b[2i+1], b[2i], b[2i-1]}, with b[-1] = 0. The digit value is b[2i-1] + b[2i] - 2*b[2i+1].
- R4 (cont.): Row i holds the N+1-bit pattern |digit|*A, bitwise inverted when the digit is negative. Its top bit is then inverted again (sign-generate form). The row is weighted 2^(2i).
- R5: The sum keeps each row bit whose weight is 2^(N-1) or above. It adds the constant -sum over i of 2^(N+2i), modulo 2^(2N). Row bits below weight 2^(N-1) are discarded, and so are the per-row negation ones, which all sit at weights below 2^(N-1).
- R6: The compensation bit is the OR of the row bits at weight 2^(N-2), one per row (row i, bit N-2-2i). It is added at weight 2^(N-1).
- R7: prod_o equals bits [2N-1:N] of the compensated sum plus bit N-1 of that sum, modulo 2^N.
- R8: The signed error prod_o*2^N - A*B is above -(N/2)*2^N and at most 2^N.
- R9: A multiplier operand of zero yields prod_o = 0 for any multiplicand.
- R10: Over all operand pairs, the mean absolute error against A*B/2^N is smaller than that of the same Booth array truncated at weight 2^N, with no compensation bit and no rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on a_i and b_i are to be multiplied |
| a_i | input | N | Multiplicand, two's complement |
| b_i | input | N | Multiplier, two's complement, Booth-recoded |
| valid_o | output | 1 | prod_o was updated at the last edge |
| prod_o | output | N | Compensated fixed-width product |

## Verification
The assertions check the following on every cycle: the valid latency, that the result holds while idle, the zero-multiplier case, and that each result stays inside the stated error window of the exact product.

Other behaviour needs the bench's scenarios. These are the bit-exact value of each result (recoding, kept columns, compensation bit, rounding), the reset state, and the statistical claim that the mean error beats plain truncation. They are shown by an exhaustive sweep of all operand pairs, compared against a behavioural model, followed by idle and zero-operand scenarios.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  // Radix-4 digit selection: magnitude one or two, optional negation
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;
endpackage

// File: rtl/fwb_booth_enc.sv
module fwb_booth_enc (
  input  logic [2:0]          trip_i,  // {b[2i+1], b[2i], b[2i-1]}
  output fwb_pkg::booth_sel_t sel_o
);
  always_comb begin
    sel_o.one = trip_i[1] ^ trip_i[0];
    sel_o.two = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
                (~trip_i[2] & trip_i[1] & trip_i[0]);
    // 111 is a zero digit, not a negated one (R4)
    sel_o.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);
  end
endmodule

// File: rtl/fwb_pp_row.sv
module fwb_pp_row #(
  parameter int N = 8
) (
  input  logic [N-1:0]        a_i,
  input  fwb_pkg::booth_sel_t sel_i,
  output logic [N:0]          row_o
);
  logic [N:0] mag;
  logic [N:0] inv;

  always_comb begin
    if (sel_i.one)      mag = {a_i[N-1], a_i};
    else if (sel_i.two) mag = {a_i, 1'b0};
    else                mag = '0;
    inv   = mag ^ {(N+1){sel_i.neg}};
    row_o = {~inv[N], inv[N-1:0]};  // sign-generate form (R4)
  end
endmodule

// File: rtl/fwb_comp_bias.sv
module fwb_comp_bias #(
  parameter int N = 8,
  localparam int R = N / 2
) (
  input  logic [R-1:0][N:0] rows_i,
  output logic              bias_o
);
  // Select the bit of row i that lands on weight 2^(N-2)
  function automatic logic [N:0] col_mask(int i);
    logic [N:0] m;
    for (int j = 0; j <= N; j++) m[j] = (2*i + j == N - 2);
    return m;
  endfunction

  always_comb begin
    bias_o = 1'b0;
    for (int i = 0; i < R; i++) bias_o = bias_o | (|(rows_i[i] & col_mask(i)));
  end
endmodule

// File: rtl/fwb_trunc_acc.sv
module fwb_trunc_acc #(
  parameter int N = 8,
  localparam int R  = N / 2,
  localparam int SW = 2 * N,
  localparam int HW = N + 1   // columns N-1 .. 2N-1
) (
  input  logic [R-1:0][N:0] rows_i,
  input  logic              bias_i,
  output logic [N-1:0]      prod_o
);
  function automatic logic [SW-1:0] sgn_const();
    logic [SW-1:0] k;
    k = '0;
    for (int i = 0; i < R; i++) k = k - (SW'(1) << (N + 2*i));
    return k;
  endfunction

  function automatic logic [N:0] keep_mask(int i);
    logic [N:0] m;
    for (int j = 0; j <= N; j++) m[j] = (2*i + j >= N - 1);
    return m;
  endfunction

  localparam logic [SW-1:0] SGN_K = sgn_const();

  logic [HW-1:0] acc;

  // All kept terms are multiples of 2^(N-1): accumulate in those units
  always_comb begin
    acc = SGN_K[SW-1:N-1] + HW'(bias_i);
    for (int i = 0; i < R; i++)
      acc = acc + HW'((SW'(rows_i[i] & keep_mask(i)) << (2*i)) >> (N - 1));
    prod_o = acc[HW-1:1] + N'(acc[0]);  // guard column rounds (R7)
  end
endmodule

// File: rtl/fwb_mult.sv
module fwb_mult #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic         valid_o,
  output logic [N-1:0] prod_o
);
  localparam int R = N / 2;

  logic [N:0]                  b_ext;
  fwb_pkg::booth_sel_t [R-1:0] sel;
  logic [R-1:0][N:0]           row_e;
  logic                        bias;
  logic [N-1:0]                prod_d;

  assign b_ext = {b_i, 1'b0};

  for (genvar i = 0; i < R; i++) begin : g_row
    fwb_booth_enc u_enc (
      .trip_i(b_ext[2*i+2:2*i]),
      .sel_o (sel[i])
    );
    fwb_pp_row #(.N(N)) u_row (
      .a_i  (a_i),
      .sel_i(sel[i]),
      .row_o(row_e[i])
    );
  end

  fwb_comp_bias #(.N(N)) u_bias (
    .rows_i(row_e),
    .bias_o(bias)
  );

  fwb_trunc_acc #(.N(N)) u_acc (
    .rows_i(row_e),
    .bias_i(bias),
    .prod_o(prod_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= prod_d;
    end
  end

  function automatic logic err_ok(logic [N-1:0] p, logic [N-1:0] a, logic [N-1:0] b);
    longint e;
    e = (longint'($signed(p)) <<< N) - longint'($signed(a)) * longint'($signed(b));
    return (e <= (longint'(1) <<< N)) && (e > -(longint'(N / 2) <<< N));
  endfunction

  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R2
  AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prod_o));  // R3
  AST_ERR_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> err_ok(prod_o, $past(a_i), $past(b_i)));  // R8
  AST_ZERO_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && b_i == '0) |=> prod_o == '0);  // R9
endmodule

// File: tb/fwb_mult_test.sv
module fwb_mult_test;
  localparam int N = 8;
  localparam int R = N / 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid;
  logic [N-1:0] a;
  logic [N-1:0] b;
  logic         valid_o;
  logic [N-1:0] prod_o;

  always #5 clk = ~clk;

  fwb_mult #(.N(N)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .valid_i(valid),
    .a_i    (a),
    .b_i    (b),
    .valid_o(valid_o),
    .prod_o (prod_o)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  ended = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // Behavioural model: sa signed multiplicand, ub multiplier bits
  function automatic int model(int sa, int ub, bit direct);
    longint t = 0;
    int     cmp = 0;
    for (int i = 0; i < R; i++) begin
      int     lo = (i == 0) ? 0 : ((ub >> (2*i - 1)) & 1);
      int     d  = lo + ((ub >> (2*i)) & 1) - 2 * ((ub >> (2*i + 1)) & 1);
      longint m  = longint'((d < 0) ? -d : d) * longint'(sa);
      longint r  = (d < 0) ? ~m : m;
      for (int j = 0; j < N; j++) begin
        int w = 2*i + j;
        if (w >= (direct ? N : N - 1)) t += ((r >> j) & 1) << w;
        if (!direct && w == N - 2 && ((r >> j) & 1) != 0) cmp = 1;
      end
      t += (((r >> N) & 1) ^ 1) << (N + 2*i);
      t -= longint'(1) << (N + 2*i);
    end
    if (!direct) t += longint'(cmp + 1) << (N - 1);
    return int'((t >>> N) & ((1 << N) - 1));
  endfunction

  function automatic int sx(int v);
    return (v >= (1 << (N - 1))) ? v - (1 << N) : v;
  endfunction

  int     exp_q[$];
  int     a_q[$];
  int     b_q[$];
  longint sum_prop = 0;
  longint sum_trunc = 0;
  longint max_err = 0;
  int     last_p = 0;

  task automatic check_pending();
    int     ep, sa, sb, tr;
    longint e, et;
    ep = exp_q.pop_front();
    sa = a_q.pop_front();
    sb = b_q.pop_front();
    chk(valid_o == 1'b1, "R2 valid_o after valid_i", valid_o, 1);
    chk(int'(prod_o) == ep, "R4 R5 R6 R7 bit-exact result", prod_o, ep);
    e  = (longint'(sx(int'(prod_o))) <<< N) - longint'(sa) * longint'(sb);
    chk((e <= (longint'(1) <<< N)) && (e > -(longint'(N / 2) <<< N)), "R8 error window", e, 0);
    tr = model(sa, sb & ((1 << N) - 1), 1'b1);
    et = (longint'(sx(tr)) <<< N) - longint'(sa) * longint'(sb);
    sum_prop  += (e < 0) ? -e : e;
    sum_trunc += (et < 0) ? -et : et;
    if (((e < 0) ? -e : e) > max_err) max_err = (e < 0) ? -e : e;
    last_p = int'(prod_o);
  endtask

  task automatic drive(int sa, int sb);
    valid = 1'b1;
    a = N'(sa);
    b = N'(sb);
    exp_q.push_back(model(sa, sb & ((1 << N) - 1), 1'b0));
    a_q.push_back(sa);
    b_q.push_back(sb);
  endtask

  initial begin
    rst_n = 1'b0;
    valid = 1'b0;
    a = '0;
    b = '0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 reset valid_o", valid_o, 0);
    chk(prod_o == '0, "R1 reset prod_o", prod_o, 0);
    rst_n = 1'b1;

    // Exhaustive sweep, one pair per cycle
    for (int sa = -(1 << (N - 1)); sa < (1 << (N - 1)); sa++) begin
      for (int sb = -(1 << (N - 1)); sb < (1 << (N - 1)); sb++) begin
        @(negedge clk);
        if (exp_q.size() != 0) check_pending();
        drive(sa, sb);
      end
    end
    @(negedge clk);
    check_pending();

    // Idle cycles with changing operands: result must hold (R3)
    for (int k = 0; k < 3; k++) begin
      valid = 1'b0;
      a = N'(5 + k);
      b = N'(-7 - k);
      @(negedge clk);
      chk(valid_o == 1'b0, "R2 valid_o low when idle", valid_o, 0);
      chk(int'(prod_o) == last_p, "R3 hold while idle", prod_o, last_p);
    end

    // Zero multiplier, extreme multiplicands (R9)
    drive(-(1 << (N - 1)), 0);
    @(negedge clk);
    void'(exp_q.pop_front()); void'(a_q.pop_front()); void'(b_q.pop_front());
    chk(prod_o == '0, "R9 zero multiplier, min multiplicand", prod_o, 0);
    drive((1 << (N - 1)) - 1, 0);
    @(negedge clk);
    void'(exp_q.pop_front()); void'(a_q.pop_front()); void'(b_q.pop_front());
    chk(prod_o == '0, "R9 zero multiplier, max multiplicand", prod_o, 0);
    valid = 1'b0;

    $display("max abs error (units 2^-%0d LSB): %0d", N, max_err);
    chk(sum_prop < sum_trunc, "R10 mean error below direct truncation", sum_prop, sum_trunc);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_up();
  end
endmodule